// File: doc/BRIEF.md
# Sampling Converter Serial Port and Power-Mode Controller

This block models the digital side of the serial port of a two-channel, 10-bit sampling converter. The host drives an active-low select line, a serial clock that idles high, and a serial data input. The block counts falling serial-clock edges from the moment select falls. It shifts a 14-bit frame out on a data line with a separate output-enable, so the line can be released to high impedance. It also picks up the channel to use for the following conversion from the serial input.

The analog side is replaced by two parallel result inputs, one per channel. The block does not gate power. It keeps a powered/asleep state and reports it as a flag. The state follows the number of falling clock edges seen before select rises again. Guard windows keep short glitches on select from putting the device to sleep or waking it up. All inputs are taken as synchronous to the system clock and are sampled on its rising edge.

Top module: `sar_port_ctrl`

## Requirements
- R1: After reset, `powered` is 1, `dout_oe` is 0 and `chan_sel` is 0.
- R2: `dout_oe` is 0 in every cycle that follows a cycle where `cs_n` was high.
- R3: In a frame that starts while powered, `dout_oe` is 1 and `dout` presents frame bit k after k falling `sclk` edges, for k from 0 to 13. The frame is two 0 bits, then the 10-bit result of the selected channel MSB first, then two 0 bits. After the 14th falling edge, `dout_oe` is 0.
- R4: If the device is powered and `cs_n` rises after fewer than 2 falling `sclk` edges, `powered` stays 1.
- R5: If the device is powered and `cs_n` rises after 2 to 9 falling `sclk` edges (inclusive), `powered` becomes 0 and `dout_oe` is released.
- R6: If the device is powered and `cs_n` rises after 10 or more falling edges but before the frame is complete, `powered` stays 1, `dout_oe` is released, and the bits driven up to that point match R3.
- R7: A frame that starts while asleep never asserts `dout_oe`.
- R8: If the device is asleep and `cs_n` rises after fewer than 10 falling `sclk` edges, `powered` stays 0.
- R9: If the device is asleep and `cs_n` rises after 10 or more falling edges, `powered` becomes 1, and the next frame returns valid result data.
- R10: `din` is sampled on the rising `sclk` edge that follows the first falling edge of a frame. A value of 1 selects channel 1 and 0 selects channel 0. The selection moves to `chan_sel` only when `cs_n` rises after all 14 falling edges, and it applies to the frames after that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; a falling edge starts a frame |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial input carrying the next channel choice |
| ch0_data | input | 10 | Conversion result for channel 0 |
| ch1_data | input | 10 | Conversion result for channel 1 |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |
| powered | output | 1 | 1 when powered, 0 when asleep |
| chan_sel | output | 1 | Channel the next conversion will use |

## Verification
The assertions check on every cycle that the data line is released once select is high, and that it is driven only while the device is powered. They also check the mode change made on each select rise against the edge count, for the short-glitch guard and the power-down window on the powered side, and for the wake guard on the asleep side. A further assertion checks that the channel register changes only at a select rise. Other behaviours need a whole frame to show and are left to the bench's scenarios. These are the bit order and zero padding of the frame, the exact edges where the windows start and end, the rule that only a completed frame commits a channel, and the return of valid data after a wake frame.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    localparam int DATA_W       = 10;
    localparam int LEAD_W       = 2;
    localparam int FRAME_LEN    = 14;
    localparam int TRAIL_W      = FRAME_LEN - LEAD_W - DATA_W;
    localparam int SLEEP_LO     = 2;
    localparam int SLEEP_HI     = 10;
    localparam int WAKE_MIN     = 10;
    localparam int CH_SAMPLE_AT = 1;
    localparam int CNT_W        = $clog2(FRAME_LEN + 1);

    typedef enum logic {
        PM_AWAKE  = 1'b0,
        PM_ASLEEP = 1'b1
    } pmode_t;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
        logic sclk_rise;
    } edges_t;

    typedef struct packed {
        logic             active;
        logic             valid;
        logic [CNT_W-1:0] cnt;
    } frame_t;

    function automatic logic [FRAME_LEN-1:0] pack_frame(input logic [DATA_W-1:0] d);
        return {{LEAD_W{1'b0}}, d, {TRAIL_W{1'b0}}};
    endfunction

endpackage

// File: rtl/sar_port_edges.sv
module sar_port_edges
    import sar_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sclk,
    output edges_t ev
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        ev.cs_fall   = cs_q & ~cs_n;
        ev.cs_rise   = ~cs_q & cs_n;
        ev.sclk_fall = ~cs_n & sclk_q & ~sclk;
        ev.sclk_rise = ~cs_n & ~sclk_q & sclk;
    end

endmodule

// File: rtl/sar_port_mode.sv
module sar_port_mode
    import sar_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  edges_t ev,
    input  logic   din,
    output frame_t frame,
    output pmode_t mode,
    output logic   chan
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_LO   = CNT_W'(SLEEP_LO);
    localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(SLEEP_HI);
    localparam logic [CNT_W-1:0] CNT_WAKE = CNT_W'(WAKE_MIN);
    localparam logic [CNT_W-1:0] CNT_CH   = CNT_W'(CH_SAMPLE_AT);

    logic   chan_pend;
    pmode_t next_mode;

    always_comb begin
        next_mode = mode;
        if (frame.active) begin
            if (mode == PM_AWAKE && frame.cnt >= CNT_LO && frame.cnt < CNT_HI)
                next_mode = PM_ASLEEP;
            else if (mode == PM_ASLEEP && frame.cnt >= CNT_WAKE)
                next_mode = PM_AWAKE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame     <= '0;
            mode      <= PM_AWAKE;
            chan      <= 1'b0;
            chan_pend <= 1'b0;
        end else if (ev.cs_fall) begin
            frame.active <= 1'b1;
            frame.valid  <= (mode == PM_AWAKE);
            frame.cnt    <= '0;
            chan_pend    <= chan;
        end else if (ev.cs_rise) begin
            frame.active <= 1'b0;
            frame.valid  <= 1'b0;
            mode         <= next_mode;
            if (frame.active && frame.cnt == CNT_FULL)
                chan <= chan_pend;
        end else if (frame.active) begin
            if (ev.sclk_fall && frame.cnt != CNT_FULL)
                frame.cnt <= frame.cnt + 1'b1;
            if (ev.sclk_rise && frame.cnt == CNT_CH)
                chan_pend <= din;
        end
    end

    // R4: a select glitch while powered leaves the device powered
    p_glitch_keeps_awake_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && frame.active && mode == PM_AWAKE && frame.cnt < CNT_LO)
        |=> mode == PM_AWAKE);

    // R5: a select rise inside the window puts the device to sleep
    p_window_sleeps_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && frame.active && mode == PM_AWAKE &&
         frame.cnt >= CNT_LO && frame.cnt < CNT_HI)
        |=> mode == PM_ASLEEP);

    // R8: a short wake attempt leaves the device asleep
    p_short_wake_sleeps_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && mode == PM_ASLEEP && frame.cnt < CNT_WAKE)
        |=> mode == PM_ASLEEP);

    // R10: the channel register moves only at a select rise
    p_chan_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !ev.cs_rise |=> $stable(chan));

    always_comb begin
        if (!rst) p_cnt_bound_r3: assert (frame.cnt <= CNT_FULL);
    end

endmodule

// File: rtl/sar_port_shift.sv
module sar_port_shift
    import sar_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  edges_t            ev,
    input  frame_t            frame,
    input  logic              chan,
    input  logic [DATA_W-1:0] ch0_data,
    input  logic [DATA_W-1:0] ch1_data,
    output logic              dout,
    output logic              dout_oe
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

    logic [FRAME_LEN-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (ev.cs_fall)
            sreg <= pack_frame(chan ? ch1_data : ch0_data);
        else if (ev.sclk_fall && frame.active)
            sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
    end

    assign dout    = sreg[FRAME_LEN-1];
    assign dout_oe = frame.active & frame.valid & (frame.cnt < CNT_FULL);

endmodule

// File: rtl/sar_port_ctrl.sv
module sar_port_ctrl
    import sar_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] ch0_data,
    input  logic [DATA_W-1:0] ch1_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              powered,
    output logic              chan_sel
);
    edges_t ev;
    frame_t frame;
    pmode_t mode;

    sar_port_edges u_edges (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .ev   (ev)
    );

    sar_port_mode u_mode (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .din   (din),
        .frame (frame),
        .mode  (mode),
        .chan  (chan_sel)
    );

    sar_port_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .frame    (frame),
        .chan     (chan_sel),
        .ch0_data (ch0_data),
        .ch1_data (ch1_data),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    assign powered = (mode == PM_AWAKE);

    // R2: line released in the cycle after select is seen high
    p_hiz_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !dout_oe);

    // R7: the line is driven only while powered
    p_drive_when_powered_r7: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> powered);

endmodule

// File: tb/sar_port_ctrl_tb.sv
module sar_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, sclk, din;
    logic [9:0] ch0_data, ch1_data;
    logic       dout, dout_oe, powered, chan_sel;

    int checks   = 0;
    int failures = 0;

    logic [15:0] bits, oes;

    always #5 clk = ~clk;

    sar_port_ctrl u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ch0_data(ch0_data), .ch1_data(ch1_data),
        .dout(dout), .dout_oe(dout_oe), .powered(powered), .chan_sel(chan_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int n, input logic sel,
                             output logic [15:0] b, output logic [15:0] e);
        b = '0;
        e = '0;
        @(negedge clk);
        cs_n = 1'b0;
        din  = ~sel;
        repeat (3) @(negedge clk);
        b[0] = dout;
        e[0] = dout_oe;
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b0;
            repeat (3) @(negedge clk);
            b[i] = dout;
            e[i] = dout_oe;
            din  = (i == 1) ? sel : ~sel;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input int n, input logic [9:0] d,
                               input logic [15:0] b, input logic [15:0] e);
        logic [13:0] word;
        logic [15:0] exp_b, exp_e;
        word  = {2'b00, d, 2'b00};
        exp_b = '0;
        exp_e = '0;
        for (int k = 0; k <= n && k < 14; k++) begin
            exp_b[k] = word[13-k];
            exp_e[k] = 1'b1;
        end
        chk({req, " enable pattern"}, {16'h0, e}, {16'h0, exp_e});
        chk({req, " data bits"}, {16'h0, b & exp_e}, {16'h0, exp_b});
    endtask

    task automatic t_reset;
        chk("R1 powered", {31'h0, powered}, 32'd1);
        chk("R1 dout_oe", {31'h0, dout_oe}, 32'd0);
        chk("R1 chan_sel", {31'h0, chan_sel}, 32'd0);
    endtask

    task automatic t_full_frames;
        run_frame(14, 1'b1, bits, oes);
        check_frame("R3 ch0 frame", 14, ch0_data, bits, oes);
        chk("R2 released after frame", {31'h0, dout_oe}, 32'd0);
        chk("R10 chan committed to 1", {31'h0, chan_sel}, 32'd1);
        run_frame(14, 1'b0, bits, oes);
        check_frame("R10 ch1 frame", 14, ch1_data, bits, oes);
        chk("R10 chan committed to 0", {31'h0, chan_sel}, 32'd0);
    endtask

    task automatic t_short_glitch;
        run_frame(1, 1'b1, bits, oes);
        chk("R4 one edge keeps powered", {31'h0, powered}, 32'd1);
        chk("R10 incomplete frame keeps chan", {31'h0, chan_sel}, 32'd0);
        run_frame(0, 1'b1, bits, oes);
        chk("R4 zero edges keeps powered", {31'h0, powered}, 32'd1);
        run_frame(14, 1'b0, bits, oes);
        check_frame("R10 still ch0", 14, ch0_data, bits, oes);
    endtask

    task automatic t_late_abort;
        run_frame(12, 1'b1, bits, oes);
        check_frame("R6 partial frame", 12, ch0_data, bits, oes);
        chk("R6 released on abort", {31'h0, dout_oe}, 32'd0);
        chk("R6 stays powered", {31'h0, powered}, 32'd1);
        chk("R10 aborted frame keeps chan", {31'h0, chan_sel}, 32'd0);
    endtask

    task automatic t_sleep_wake;
        run_frame(2, 1'b0, bits, oes);
        chk("R5 two edges sleeps", {31'h0, powered}, 32'd0);
        chk("R5 released", {31'h0, dout_oe}, 32'd0);
        run_frame(9, 1'b0, bits, oes);
        chk("R7 asleep frame not driven", {16'h0, oes}, 32'd0);
        chk("R8 nine edges stays asleep", {31'h0, powered}, 32'd0);
        run_frame(10, 1'b0, bits, oes);
        chk("R7 wake frame not driven", {16'h0, oes}, 32'd0);
        chk("R9 ten edges wakes", {31'h0, powered}, 32'd1);
        run_frame(14, 1'b0, bits, oes);
        check_frame("R9 valid after wake", 14, ch0_data, bits, oes);
        run_frame(9, 1'b0, bits, oes);
        chk("R5 nine edges sleeps", {31'h0, powered}, 32'd0);
        run_frame(14, 1'b1, bits, oes);
        chk("R7 full asleep frame not driven", {16'h0, oes}, 32'd0);
        chk("R9 full wake frame wakes", {31'h0, powered}, 32'd1);
        chk("R10 wake frame commits chan", {31'h0, chan_sel}, 32'd1);
        run_frame(14, 1'b1, bits, oes);
        check_frame("R9 ch1 after wake", 14, ch1_data, bits, oes);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        cs_n     = 1'b1;
        sclk     = 1'b1;
        din      = 1'b0;
        ch0_data = 10'h2A5;
        ch1_data = 10'h15C;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_full_frames();
        t_short_glitch();
        t_late_abort();
        t_sleep_wake();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule